// File: doc/BRIEF.md
# Two-Wire Register Bank Target

This block is a target (slave) on a two-wire serial bus. It holds a small bank of 8-bit registers that a bus controller can write and read. Both bus lines are sampled by the system clock, which must run well above the bus bit rate. The block never drives the data line high: it only asserts an output enable that pulls the shared line low. The controller can use a single-register access or a burst, and in both cases the register pointer advances by itself.

A write sends the device address with the write direction, then one byte that loads the register pointer, then any number of data bytes. A read first sets the pointer with a short write. The controller then issues a repeated START and sends the device address with the read direction. The block returns register contents for as long as the controller acknowledges. User logic sees every committed register write as a one-cycle strobe with address and data. It can also read any register through a separate asynchronous read port.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START is SDA falling while SCL is high. It begins reception of an address byte from any state. A START during a transfer acts as a repeated START: the transfer in progress is abandoned and the next byte is treated as an address byte.
- R2: The address byte carries 7 address bits, MSB first, then a direction bit (0 = write, 1 = read). When the 7 bits equal `dev_addr`, the block pulls SDA low during the ninth (acknowledge) clock.
- R3: For any other address, SDA stays released in the acknowledge clock and in every clock that follows, until the next START or STOP. No register changes.
- R4: In a write, the first byte after the address sets the register pointer. The next byte is stored at the pointer, and its acknowledge is given. Each stored byte produces exactly one single-cycle `wr_stb` pulse carrying its address and data.
- R5: Each further write byte without a STOP goes to pointer + 1 and is acknowledged. The 8-bit pointer wraps from FFh to 00h.
- R6: After a read address byte is acknowledged, the block shifts out the register at the pointer, MSB first. SDA output changes only while SCL is low.
- R7: During a read, a controller acknowledge (SDA low in the ninth clock) makes the block send the next register. A not-acknowledge makes it release SDA and send nothing more until START or STOP.
- R8: The general-call write address (byte 00h) is acknowledged, and so are its data bytes. None of them changes any register or pulses `wr_stb`. A general-call address with the read bit (byte 01h) is not acknowledged.
- R9: The bank holds 16 registers. Writes to a pointer of 10h or above are acknowledged and discarded. Reads at such a pointer return 00h.
- R10: A STOP is SDA rising while SCL is high. It returns the block to idle with SDA released. Bytes clocked without a new START are then not acknowledged.
- R11: After reset, all registers read 00h, SDA is released, and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr | input | 7 | Device address this target answers to |
| sda_oe | output | 1 | High pulls the bus data line low |
| wr_stb | output | 1 | One-cycle pulse for each stored register write |
| wr_addr | output | 4 | Register index of the stored write |
| wr_data | output | 8 | Value of the stored write |
| usr_raddr | input | 4 | User read port register index |
| usr_rdata | output | 8 | User read port data, combinational |

## Verification
The bench drives the bus with several patterns.

- A single-burst write followed by a pointer-set read separates the pointer byte from the data bytes.
- A two-byte read, ended by a controller not-acknowledge and one extra clock, tells acknowledge-continue apart from release.
- Foreign-address and general-call traffic show that acknowledging a byte and storing it are decided separately.
- Bursts that cross 0Fh to 10h, and FFh to 00h, separate range discard from pointer wrap.
- A repeated START inside a write shows that the new pointer overrides the old one.
- A STOP followed by an orphan byte shows that STOP really returns the block to idle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } link_state_e;

    // conditioned view of the two bus lines
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // register write request from the protocol engine
    typedef struct packed {
        logic  stb;
        byte_t ptr;
        byte_t data;
    } wr_req_t;

    function automatic logic is_gcall(input logic [6:0] a);
        return a == 7'h00;
    endfunction

    function automatic logic ptr_in_range(input byte_t p, input int unsigned n);
        return 32'(p) < n;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] pin;
    logic [LINES-1:0] sh [STAGES];
    logic [LINES-1:0] prev;
    logic [LINES-1:0] cur;

    assign pin = {scl_i, sda_i};

    // bus lines idle high, so the chain resets to ones
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) sh[k] <= '1;
            prev <= '1;
        end else begin
            sh[0] <= pin;
            for (int k = 1; k < STAGES; k++) sh[k] <= sh[k-1];
            prev <= sh[STAGES-1];
        end
    end

    assign cur = sh[STAGES-1];

    always_comb begin
        ev.scl      = cur[1];
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store
    import i2c_tgt_pkg::*;
#(
    parameter int N_REGS = 16,   // at most 256, the pointer range
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  byte_t         bus_ptr,
    output byte_t         bus_rdata,
    input  logic [AW-1:0] usr_raddr,
    output byte_t         usr_rdata,
    output logic          wr_stb_o,
    output logic [AW-1:0] wr_addr_o,
    output byte_t         wr_data_o
);

    byte_t regs [N_REGS];
    logic  hit;

    assign hit = wr.stb && ptr_in_range(wr.ptr, N_REGS);

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[r] <= '0;
            end else if (hit && wr.ptr[AW-1:0] == AW'(r)) begin
                regs[r] <= wr.data;
            end
        end
    end

    assign bus_rdata = ptr_in_range(bus_ptr, N_REGS) ? regs[bus_ptr[AW-1:0]] : '0;
    assign usr_rdata = regs[usr_raddr];

    assign wr_stb_o  = hit;
    assign wr_addr_o = wr.ptr[AW-1:0];
    assign wr_data_o = wr.data;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_ev_t    ev,
    input  logic [6:0]  dev_addr,
    input  byte_t       rd_byte,
    output logic        sda_oe,
    output wr_req_t     wr,
    output byte_t       ptr,
    output link_state_e state,
    output logic        gcall
);

    link_state_e ack_next;
    logic        ack_want;
    logic        ack_phase;
    logic [3:0]  bitcnt;
    byte_t       shreg;
    byte_t       tx;
    byte_t       rx;
    logic        hit_own;
    logic        hit_gc;

    assign rx      = {shreg[6:0], ev.sda};
    assign hit_own = rx[7:1] == dev_addr;
    assign hit_gc  = is_gcall(rx[7:1]) && !rx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ack_next  <= ST_SKIP;
            ack_want  <= 1'b0;
            ack_phase <= 1'b0;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            gcall     <= 1'b0;
            sda_oe    <= 1'b0;
            wr        <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state     <= ST_ADDR;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_REG, ST_WDAT: begin
                        if (ev.scl_rise) begin
                            shreg <= rx;
                            if (bitcnt == 4'd7) begin
                                bitcnt    <= '0;
                                ack_phase <= 1'b0;
                                state     <= ST_ACK;
                                if (state == ST_ADDR) begin
                                    gcall <= !hit_own && hit_gc;
                                    if (hit_own) begin
                                        ack_want <= 1'b1;
                                        ack_next <= rx[0] ? ST_TX : ST_REG;
                                    end else if (hit_gc) begin
                                        ack_want <= 1'b1;
                                        ack_next <= ST_REG;
                                    end else begin
                                        ack_want <= 1'b0;
                                        ack_next <= ST_SKIP;
                                    end
                                end else if (state == ST_REG) begin
                                    ptr      <= rx;
                                    ack_want <= 1'b1;
                                    ack_next <= ST_WDAT;
                                end else begin
                                    wr.stb   <= !gcall;
                                    wr.ptr   <= ptr;
                                    wr.data  <= rx;
                                    ptr      <= ptr + 8'd1;
                                    ack_want <= 1'b1;
                                    ack_next <= ST_WDAT;
                                end
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_phase) begin
                                ack_phase <= 1'b1;
                                sda_oe    <= ack_want;
                            end else begin
                                ack_phase <= 1'b0;
                                bitcnt    <= '0;
                                state     <= ack_next;
                                if (ack_next == ST_TX) begin
                                    tx     <= rd_byte;
                                    sda_oe <= ~rd_byte[7];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 8'd1;
                                state  <= ST_MACK;
                            end else begin
                                tx     <= tx << 1;
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            ack_want <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (ack_want) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                state  <= ST_TX;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int N_REGS      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [6:0]    dev_addr,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic [AW-1:0] usr_raddr,
    output logic [7:0]    usr_rdata
);

    line_ev_t    ev;
    wr_req_t     wr;
    byte_t       ptr;
    byte_t       rd_byte;
    link_state_e link_state;
    logic        gcall;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_link_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .dev_addr (dev_addr),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .wr       (wr),
        .ptr      (ptr),
        .state    (link_state),
        .gcall    (gcall)
    );

    i2c_reg_store #(.N_REGS(N_REGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .bus_ptr   (ptr),
        .bus_rdata (rd_byte),
        .usr_raddr (usr_raddr),
        .usr_rdata (usr_rdata),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk
    import i2c_tgt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sda_oe,
    input logic        scl_s,
    input logic        start_det,
    input logic        stop_det,
    input link_state_e state,
    input logic        gcall,
    input logic        wr_stb
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det || stop_det))); // R6

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R10

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det) |=> (state == ST_ADDR && !sda_oe)); // R1

    AST_GCALL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !gcall); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R4

    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe); // R3

endmodule

bind i2c_regbank_target i2c_regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_s     (ev.scl),
    .start_det (ev.start),
    .stop_det  (ev.stop),
    .state     (link_state),
    .gcall     (gcall),
    .wr_stb    (wr_stb)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] dev_addr = 7'h2A;
    logic       sda_oe;
    logic       wr_stb;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] usr_raddr = 4'd0;
    logic [7:0] usr_rdata;
    logic       sda_bus;

    int    n_chk = 0;
    int    n_bad = 0;
    int    wr_cnt = 0;
    int    exp_v[$];
    string exp_r[$];
    int    obs_v[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regbank_target u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .dev_addr  (dev_addr),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .usr_raddr (usr_raddr),
        .usr_rdata (usr_rdata)
    );

    task automatic chk(input int act, input int expv, input string req, input string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic quarter();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b0; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b1; quarter();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    quarter();
        scl_m = 1'b1; quarter(); quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        b = sda_bus;  quarter();
        scl_m = 1'b0; quarter();
    endtask

    // driver: expected acknowledge level (0 = ack, 1 = nack) goes to the scoreboard
    task automatic put_byte(input logic [7:0] v, input logic exp_nack, input string req);
        logic a;
        exp_v.push_back(int'(exp_nack));
        exp_r.push_back(req);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        obs_v.push_back(int'(a));
    endtask

    task automatic get_byte(input logic [7:0] expv, input logic mack, input string req);
        logic [7:0] v;
        logic       b;
        exp_v.push_back(int'(expv));
        exp_r.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        obs_v.push_back(int'(v));
        bit_out(!mack);
    endtask

    task automatic peek(input int idx, input int expv, input string req);
        usr_raddr = 4'(idx);
        @(negedge clk);
        chk(int'(usr_rdata), expv, req, $sformatf("register %0d", idx));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // monitor: compares observed bus items against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            while (obs_v.size() != 0) begin
                int a;
                a = obs_v.pop_front();
                if (exp_v.size() == 0) begin
                    chk(a, -1, "scoreboard", "unexpected bus item");
                end else begin
                    chk(a, exp_v.pop_front(), exp_r.pop_front(), "bus item");
                end
            end
        end
    end

    always @(negedge clk) if (!rst && wr_stb) wr_cnt++;

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk(int'(sda_oe), 0, "R11", "sda_oe after reset");
        peek(0, 8'h00, "R11");
        peek(15, 8'h00, "R11");

        // R2 R4 R5 burst write
        bus_start();
        put_byte(8'h54, 1'b0, "R2");
        put_byte(8'h02, 1'b0, "R4");
        put_byte(8'hA5, 1'b0, "R4");
        put_byte(8'h3C, 1'b0, "R5");
        bus_stop();
        peek(2, 8'hA5, "R4");
        peek(3, 8'h3C, "R5");
        chk(wr_cnt, 2, "R4", "strobe count");

        // R6 R7 pointer set, repeated START, burst read ending in nack
        bus_start();
        put_byte(8'h54, 1'b0, "R6");
        put_byte(8'h02, 1'b0, "R6");
        bus_start();
        put_byte(8'h55, 1'b0, "R2");
        get_byte(8'hA5, 1'b1, "R6");
        get_byte(8'h3C, 1'b0, "R7");
        begin
            logic b;
            exp_v.push_back(1);
            exp_r.push_back("R7");
            bit_in(b);
            obs_v.push_back(int'(b));
        end
        bus_stop();

        // R3 foreign address
        bus_start();
        put_byte(8'h22, 1'b1, "R3");
        put_byte(8'h05, 1'b1, "R3");
        put_byte(8'hEE, 1'b1, "R3");
        bus_stop();
        peek(5, 8'h00, "R3");

        // R8 general call
        bus_start();
        put_byte(8'h00, 1'b0, "R8");
        put_byte(8'h04, 1'b0, "R8");
        put_byte(8'h77, 1'b0, "R8");
        bus_stop();
        peek(4, 8'h00, "R8");
        chk(wr_cnt, 2, "R8", "strobe count after general call");
        bus_start();
        put_byte(8'h01, 1'b1, "R8");
        bus_stop();

        // R9 range edge
        bus_start();
        put_byte(8'h54, 1'b0, "R9");
        put_byte(8'h0F, 1'b0, "R9");
        put_byte(8'h11, 1'b0, "R9");
        put_byte(8'h22, 1'b0, "R9");
        bus_stop();
        peek(15, 8'h11, "R9");
        peek(0, 8'h00, "R9");
        chk(wr_cnt, 3, "R9", "strobe count after range edge");
        bus_start();
        put_byte(8'h54, 1'b0, "R9");
        put_byte(8'h10, 1'b0, "R9");
        bus_start();
        put_byte(8'h55, 1'b0, "R9");
        get_byte(8'h00, 1'b0, "R9");
        bus_stop();

        // R5 pointer wrap
        bus_start();
        put_byte(8'h54, 1'b0, "R5");
        put_byte(8'hFF, 1'b0, "R5");
        put_byte(8'h99, 1'b0, "R5");
        put_byte(8'h66, 1'b0, "R5");
        bus_stop();
        peek(0, 8'h66, "R5");
        chk(wr_cnt, 4, "R5", "strobe count after wrap");

        // R1 repeated START inside a write
        bus_start();
        put_byte(8'h54, 1'b0, "R1");
        put_byte(8'h07, 1'b0, "R1");
        bus_start();
        put_byte(8'h54, 1'b0, "R1");
        put_byte(8'h08, 1'b0, "R1");
        put_byte(8'h5A, 1'b0, "R1");
        bus_stop();
        peek(8, 8'h5A, "R1");
        peek(7, 8'h00, "R1");

        // R10 STOP then orphan byte
        bus_start();
        put_byte(8'h54, 1'b0, "R10");
        put_byte(8'h09, 1'b0, "R10");
        bus_stop();
        chk(int'(sda_oe), 0, "R10", "sda_oe after stop");
        scl_m = 1'b0; quarter();
        put_byte(8'h42, 1'b1, "R10");
        bus_stop();
        peek(9, 8'h00, "R10");

        repeat (20) @(negedge clk);
        chk(exp_v.size(), 0, "scoreboard", "items left unmatched");
        summary();
        $finish;
    end

endmodule